// File: doc/BRIEF.md
# Grouped Pixel Hit Readout with Window Timestamps

This block reads out a pixel hit matrix whose pixels are grouped into square macropixels of four by four. Each pixel keeps a latch that records a rising edge on its discriminator input. Each group raises one private flag line when any of its pixels has fired. A single-cycle window strobe closes the current time window. The block then swaps the live latches into a frozen copy, tags the window with a timestamp, and scans only the flagged groups. It enables one group at a time onto shared data lines and sends one formatted word per fired pixel to a valid-qualified output.

Pixels keep collecting into the live latches while the frozen copy is being drained. A strobe that arrives during a readout sets a sticky overflow flag. Such a strobe does not swap the latches: the running readout completes in full, and the hits collected meanwhile are reported with the next accepted window.

Top module: `mrd_readout`

## Requirements
- R1: After reset, `valid_o` and `ovf_o` are 0, and a strobe closing a window with no hits produces no output word.
- R2: A pixel latch sets only on a 0-to-1 transition of its input. A level held high over several windows is reported once, and is reported again only after it falls and rises.
- R3: When a window holds at least one hit, the first output word is valid exactly 9 clock cycles after the clock edge that samples the accepted strobe.
- R4: Within one window, groups are read in ascending group address. The group address is (row/4)*(COLS/4) + col/4.
- R5: Within a group, fired pixels are emitted on consecutive cycles in ascending index. The index is (row%4)*4 + col%4.
- R6: An output word is {timestamp[19:12], group address[11:4], pixel index[3:0]} with the default parameters.
- R7: The timestamp of a window equals the number of strobes seen before the strobe that closes it, modulo 256. Every strobe advances the count, including rejected ones.
- R8: Rising edges that occur after an accepted strobe, including those during its readout, are kept and reported with the next accepted window.
- R9: A strobe arriving while a readout is still busy sets `ovf_o`, which stays set until reset. The busy window is still fully drained, and hits collected since the last accepted strobe come out at the next accepted strobe.
- R10: At full occupancy, when all 4096 pixels fire in one window, exactly 4096 words come out in ascending group and pixel order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | COLS*ROWS | Discriminator outputs, bit row*COLS+col |
| win_i | input | 1 | One-cycle window strobe |
| valid_o | output | 1 | Output word qualifier |
| word_o | output | TS_W+GA_W+IDX_W | Timestamp, group address, pixel index |
| ovf_o | output | 1 | Sticky overflow: strobe seen while busy |

## Verification
The hardest situation to reach is a strobe landing inside a running readout while fresh hits arrive. The stimulus fires all 32 pixels of one row, which keeps the scanner busy for about fifty cycles. A second strobe is issued four cycles later, inside the start-up wait, and a new pixel is pulsed after it. The bench then checks that the first window drains intact and that the late pixel appears only after a third strobe, with that strobe's timestamp. A full-occupancy window tests the ordering of all 4096 words.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_LOAD = 2'd2,
      ST_EMIT = 2'd3
   } scan_st_t;
endpackage

// File: rtl/mrd_first_set.sv
module mrd_first_set #(
   parameter int N  = 16,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  in_i,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);
   generate
      if (N < 2) begin : g_bad
         $error("mrd_first_set needs N >= 2");
      end
   endgenerate

   always_comb begin
      idx_o = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (in_i[k]) idx_o = IW'(k);
      end
   end

   assign any_o = |in_i;
endmodule

// File: rtl/mrd_group.sv
module mrd_group #(
   parameter int GW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [GW-1:0] disc_i,
   input  logic          swap_i,
   input  logic          en_i,
   output logic          flag_o,
   output logic [GW-1:0] data_o
);
   logic [GW-1:0] prev_q, live_q, held_q, rise;

   assign rise = disc_i & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         live_q <= '0;
         held_q <= '0;
      end else begin
         prev_q <= disc_i;
         if (swap_i) begin
            held_q <= live_q | rise;
            live_q <= '0;
         end else begin
            live_q <= live_q | rise;
            if (en_i) held_q <= '0;
         end
      end
   end

   assign flag_o = |held_q;
   assign data_o = en_i ? held_q : '0;

   // R8
   swap_en_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swap_i |-> !en_i);

   // R8
   live_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!swap_i && $past(!swap_i) && (|$past(live_q))) |-> (|live_q));
endmodule

// File: rtl/mrd_scan.sv
module mrd_scan
   import mrd_pkg::*;
#(
   parameter int NGRP  = 256,
   parameter int GW    = 16,
   parameter int TS_W  = 8,
   parameter int LAT   = 9,
   parameter int GA_W  = $clog2(NGRP),
   parameter int IDX_W = $clog2(GW),
   parameter int WW    = TS_W + GA_W + IDX_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            win_i,
   input  logic [NGRP-1:0] flags_i,
   input  logic [GW-1:0]   bus_i,
   output logic            swap_o,
   output logic [NGRP-1:0] en_o,
   output logic            valid_o,
   output logic [WW-1:0]   word_o,
   output logic            ovf_o
);
   localparam int CW = $clog2(LAT + 2) + 1;

   generate
      if (LAT < 3) begin : g_bad_lat
         $error("mrd_scan needs LAT >= 3");
      end
   endgenerate

   scan_st_t         st_q;
   logic [CW-1:0]    cnt_q;
   logic [TS_W-1:0]  ts_cnt_q, ts_win_q;
   logic [GA_W-1:0]  grp_q, sel_g;
   logic [IDX_W-1:0] sel_p;
   logic [GW-1:0]    pix_q, pix_nx;
   logic             any_g, any_p;

   mrd_first_set #(.N(NGRP), .IW(GA_W)) u_gsel (
      .in_i(flags_i), .idx_o(sel_g), .any_o(any_g));
   mrd_first_set #(.N(GW), .IW(IDX_W)) u_psel (
      .in_i(pix_q), .idx_o(sel_p), .any_o(any_p));

   assign swap_o = win_i && (st_q == ST_IDLE);

   genvar gi;
   generate
      for (gi = 0; gi < NGRP; gi++) begin : g_en
         assign en_o[gi] = (st_q == ST_LOAD) && (sel_g == GA_W'(gi));
      end
   endgenerate

   always_comb begin
      pix_nx = pix_q;
      pix_nx[sel_p] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         cnt_q    <= '0;
         ts_cnt_q <= '0;
         ts_win_q <= '0;
         grp_q    <= '0;
         pix_q    <= '0;
         valid_o  <= 1'b0;
         word_o   <= '0;
         ovf_o    <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (win_i) ts_cnt_q <= ts_cnt_q + 1'b1;
         if (win_i && st_q != ST_IDLE) ovf_o <= 1'b1;
         case (st_q)
            ST_IDLE: if (win_i) begin
               st_q     <= ST_WAIT;
               cnt_q    <= '0;
               ts_win_q <= ts_cnt_q;
            end
            ST_WAIT: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CW'(LAT - 3)) st_q <= any_g ? ST_LOAD : ST_IDLE;
            end
            ST_LOAD: begin
               grp_q <= sel_g;
               pix_q <= bus_i;
               st_q  <= ST_EMIT;
            end
            default: begin
               valid_o <= any_p;
               word_o  <= {ts_win_q, grp_q, sel_p};
               pix_q   <= pix_nx;
               if (pix_nx == '0) st_q <= any_g ? ST_LOAD : ST_IDLE;
            end
         endcase
      end
   end

   logic [CW-1:0] since_q;
   logic          first_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_q <= '0;
         first_q <= 1'b0;
      end else if (swap_o) begin
         since_q <= '0;
         first_q <= 1'b1;
      end else begin
         if (since_q != '1) since_q <= since_q + 1'b1;
         if (valid_o) first_q <= 1'b0;
      end
   end

   // R3
   first_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && first_q) |-> (since_q == CW'(LAT)));

   // R5
   idx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && $past(valid_o) &&
       word_o[IDX_W +: GA_W] == $past(word_o[IDX_W +: GA_W]))
      |-> (word_o[IDX_W-1:0] > $past(word_o[IDX_W-1:0])));

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ovf_o) |-> ovf_o);

   // R1
   quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && $past(st_q == ST_IDLE)) |-> !valid_o);
endmodule

// File: rtl/mrd_readout.sv
module mrd_readout #(
   parameter int COLS  = 32,
   parameter int ROWS  = 128,
   parameter int MP    = 4,
   parameter int TS_W  = 8,
   parameter int LAT   = 9,
   parameter int GC    = COLS / MP,
   parameter int NGRP  = GC * (ROWS / MP),
   parameter int GA_W  = $clog2(NGRP),
   parameter int IDX_W = $clog2(MP * MP)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [COLS*ROWS-1:0]        hit_i,
   input  logic                        win_i,
   output logic                        valid_o,
   output logic [TS_W+GA_W+IDX_W-1:0]  word_o,
   output logic                        ovf_o
);
   localparam int GR = ROWS / MP;
   localparam int GW = MP * MP;

   generate
      if ((COLS % MP) != 0 || (ROWS % MP) != 0) begin : g_bad_dim
         $error("mrd_readout: matrix must divide into whole groups");
      end
   endgenerate

   logic [NGRP-1:0] flags, en;
   logic [GW-1:0]   gdata [NGRP];
   logic [GW-1:0]   bus;
   logic            swap;

   genvar gy, gx, r, c;
   generate
      for (gy = 0; gy < GR; gy++) begin : g_row
         for (gx = 0; gx < GC; gx++) begin : g_col
            logic [GW-1:0] disc;
            for (r = 0; r < MP; r++) begin : g_pr
               for (c = 0; c < MP; c++) begin : g_pc
                  assign disc[r*MP+c] = hit_i[(gy*MP+r)*COLS + gx*MP + c];
               end
            end
            mrd_group #(.GW(GW)) u_grp (
               .clk   (clk),
               .rst_n (rst_n),
               .disc_i(disc),
               .swap_i(swap),
               .en_i  (en[gy*GC+gx]),
               .flag_o(flags[gy*GC+gx]),
               .data_o(gdata[gy*GC+gx])
            );
         end
      end
   endgenerate

   always_comb begin
      bus = '0;
      for (int k = 0; k < NGRP; k++) bus = bus | gdata[k];
   end

   mrd_scan #(.NGRP(NGRP), .GW(GW), .TS_W(TS_W), .LAT(LAT),
              .GA_W(GA_W), .IDX_W(IDX_W)) u_scan (
      .clk    (clk),
      .rst_n  (rst_n),
      .win_i  (win_i),
      .flags_i(flags),
      .bus_i  (bus),
      .swap_o (swap),
      .en_o   (en),
      .valid_o(valid_o),
      .word_o (word_o),
      .ovf_o  (ovf_o)
   );

   // R4
   en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(en));
endmodule

// File: tb/mrd_readout_tb_top.sv
module mrd_readout_tb_top;
   localparam int COLS = 32;
   localparam int ROWS = 128;
   localparam int NPIX = COLS * ROWS;
   localparam int WW   = 20;
   localparam int LOGN = 4200;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NPIX-1:0] hits = '0;
   logic            win = 1'b0;
   logic            valid, ovf;
   logic [WW-1:0]   word;

   always #4 clk = ~clk;

   mrd_readout dut_i (
      .clk(clk), .rst_n(rst_n), .hit_i(hits), .win_i(win),
      .valid_o(valid), .word_o(word), .ovf_o(ovf));

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [WW-1:0] lw [LOGN];
   int            lc [LOGN];
   int            nw = 0;
   always @(negedge clk) begin
      if (valid && nw < LOGN) begin
         lw[nw] = word;
         lc[nw] = cyc;
         nw = nw + 1;
      end
   end

   int errors = 0, checks = 0, nstrobe = 0, s_cyc = 0, s_ts = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [WW-1:0] ew(int r, int c, int ts);
      int g, i;
      g = (r / 4) * (COLS / 4) + c / 4;
      i = (r % 4) * 4 + c % 4;
      return {ts[7:0], g[7:0], i[3:0]};
   endfunction

   task automatic strobe();
      @(negedge clk) win = 1'b1;
      @(posedge clk);
      #1 s_cyc = cyc;
      s_ts = nstrobe;
      nstrobe++;
      @(negedge clk) win = 1'b0;
   endtask

   task automatic pulse_px(int r, int c);
      @(negedge clk) hits[r*COLS+c] = 1'b1;
      @(negedge clk) hits[r*COLS+c] = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      int b;
      chk(valid == 1'b0, "R1", "valid after reset", valid, 0);
      chk(ovf == 1'b0, "R1", "ovf after reset", ovf, 0);
      b = nw;
      strobe();
      idle(30);
      chk(nw == b, "R1", "words for empty window", nw - b, 0);
   endtask

   task automatic t_single();
      int b;
      b = nw;
      pulse_px(5, 9);
      strobe();
      idle(30);
      chk(nw - b == 1, "R3", "single hit word count", nw - b, 1);
      chk(lc[b] - s_cyc == 9, "R3", "first word latency", lc[b] - s_cyc, 9);
      chk(lw[b] == ew(5, 9, s_ts), "R6", "single word format", lw[b], ew(5, 9, s_ts));
      chk(lw[b][19:12] == 8'(s_ts), "R7", "timestamp tag", lw[b][19:12], s_ts);
   endtask

   task automatic t_order();
      int b;
      logic [WW-1:0] e [4];
      b = nw;
      pulse_px(127, 0);
      pulse_px(0, 31);
      pulse_px(2, 2);
      pulse_px(1, 3);
      strobe();
      idle(60);
      e[0] = ew(1, 3, s_ts);
      e[1] = ew(2, 2, s_ts);
      e[2] = ew(0, 31, s_ts);
      e[3] = ew(127, 0, s_ts);
      chk(nw - b == 4, "R4", "multi group count", nw - b, 4);
      for (int k = 0; k < 4; k++)
         chk(lw[b+k] == e[k], "R4", "ascending group/pixel word", lw[b+k], e[k]);
      chk(lc[b+1] - lc[b] == 1, "R5", "same group consecutive", lc[b+1] - lc[b], 1);
      chk(lc[b] - s_cyc == 9, "R3", "latency multi group", lc[b] - s_cyc, 9);
   endtask

   task automatic t_level();
      int b;
      @(negedge clk) hits[10*COLS+20] = 1'b1;
      b = nw;
      strobe();
      idle(30);
      chk(nw - b == 1, "R2", "held level first window", nw - b, 1);
      b = nw;
      strobe();
      idle(30);
      chk(nw - b == 0, "R2", "held level no re-hit", nw - b, 0);
      @(negedge clk) hits[10*COLS+20] = 1'b0;
      idle(2);
      pulse_px(10, 20);
      b = nw;
      strobe();
      idle(30);
      chk(nw - b == 1, "R2", "re-rise is hit again", nw - b, 1);
      chk(lw[b] == ew(10, 20, s_ts), "R2", "re-rise word", lw[b], ew(10, 20, s_ts));
   endtask

   task automatic t_during();
      int b;
      b = nw;
      pulse_px(0, 0);
      strobe();
      idle(3);
      pulse_px(4, 4);
      idle(30);
      chk(nw - b == 1, "R8", "only prior window drained", nw - b, 1);
      chk(lw[b] == ew(0, 0, s_ts), "R8", "prior window word", lw[b], ew(0, 0, s_ts));
      b = nw;
      strobe();
      idle(30);
      chk(nw - b == 1, "R8", "late hit next window count", nw - b, 1);
      chk(lw[b] == ew(4, 4, s_ts), "R8", "late hit next window word", lw[b], ew(4, 4, s_ts));
   endtask

   task automatic t_overflow();
      int b, bad, ta;
      b = nw;
      @(negedge clk) hits[COLS-1:0] = '1;
      @(negedge clk) hits[COLS-1:0] = '0;
      strobe();
      ta = s_ts;
      idle(4);
      strobe();
      pulse_px(8, 8);
      idle(100);
      chk(ovf == 1'b1, "R9", "overflow flag set", ovf, 1);
      chk(nw - b == 32, "R9", "busy window fully drained", nw - b, 32);
      bad = 0;
      for (int k = 0; k < 32; k++) if (lw[b+k] != ew(0, k, ta)) bad++;
      chk(bad == 0, "R9", "drained words mismatches", bad, 0);
      b = nw;
      strobe();
      idle(30);
      chk(nw - b == 1, "R9", "merged hit count", nw - b, 1);
      chk(lw[b] == ew(8, 8, s_ts), "R7", "tag after rejected strobe", lw[b], ew(8, 8, s_ts));
   endtask

   task automatic t_full();
      int b, bad;
      logic [WW-1:0] e;
      b = nw;
      @(negedge clk) hits = '1;
      @(negedge clk) hits = '0;
      strobe();
      idle(4500);
      chk(nw - b == 4096, "R10", "full occupancy count", nw - b, 4096);
      bad = 0;
      for (int k = 0; k < 4096; k++) begin
         e = {8'(s_ts), 12'(k)};
         if (b + k < LOGN && lw[b+k] != e) bad++;
      end
      chk(bad == 0, "R10", "full occupancy order mismatches", bad, 0);
      chk(lc[b] - s_cyc == 9, "R3", "latency at full occupancy", lc[b] - s_cyc, 9);
      chk(ovf == 1'b1, "R9", "overflow still sticky", ovf, 1);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle(5);
      @(negedge clk) rst_n = 1'b1;
      idle(2);
      t_reset();
      t_single();
      t_order();
      t_level();
      t_during();
      t_overflow();
      t_full();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule